// File: doc/BRIEF.md
# Table-Driven I2C Initialization Sequencer

This block walks a constant table of 17-bit steps once after reset and turns each step into an action. A step either writes one byte into a register of an I2C slave, or performs a control operation. The control operations are: choose the slave address byte used by later writes, set the level of a general-purpose reset output, or pause for a number of milliseconds. Bus timing is not generated here. Every register write is handed to a separate byte-write engine through a request/done handshake. The per-byte acknowledge error flags that the engine reports are kept for inspection.

The table, its length and the clock rate in kHz are parameters. The millisecond pause is counted by a prescaler derived from that clock rate. When the last step has completed the block raises a done flag and stays idle. A reset, or a one-cycle restart pulse, runs the table again from step 0.

Top module: `i2c_init_sequencer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rstOut`=0, `ackErr`=0, `wrReq`=0 and `seqDone`=0. Step 0 is executed on the first clock edge with `rst` low.
- R2: A step is `{func[16], regSel[15:8], val[7:0]}`. With func=1 and regSel=0x00, val becomes the device address byte, with the read/write bit in its LSB. Every later write request presents this byte on `wrDev`.
- R3: With func=1 and regSel=0x01, `rstOut` takes bit 0 of val from the following cycle.
- R4: With func=1 and regSel=0x02, the sequencer pauses for val milliseconds, where one millisecond is CLK_KHZ cycles and val=0 means 256 ms. The next step is fetched exactly val*CLK_KHZ cycles after the pause began.
- R5: With func=1 and any regSel from 0x03 to 0xFF, the step has no effect on any output and the sequence moves on.
- R6: With func=0, `wrReq` rises one cycle after the step is fetched. `{wrDev, wrReg, wrData}` = {device byte, regSel, val}. Request and payload hold steady until the cycle in which `wrDone` is high.
- R7: `ackErr` loads `wrAckErr` on a cycle with both `wrReq` and `wrDone` high. Bit 0 flags the address byte, bit 1 the register byte and bit 2 the data byte. A `wrDone` pulse while no request is pending leaves `ackErr` unchanged.
- R8: Address, reset-level and no-op steps each take one cycle. After a write completes or a pause expires, the next step is fetched on the following cycle.
- R9: One cycle after the final step completes, `seqDone` rises. It stays high with no further requests until a reset or restart.
- R10: A `restart` pulse clears `seqDone`, drops any pending request, and re-runs the table from step 0. The device byte, `rstOut` and `ackErr` keep their values until steps overwrite them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | One-cycle pulse that re-runs the table from step 0 |
| rstOut | output | 1 | General-purpose reset level set by table steps |
| wrReq | output | 1 | Register write request to the byte-write engine |
| wrDev | output | 8 | Device address byte of the request |
| wrReg | output | 8 | Register address of the request |
| wrData | output | 8 | Data byte of the request |
| wrDone | input | 1 | Engine completion pulse |
| wrAckErr | input | 3 | Per-byte missing-acknowledge flags from the engine |
| ackErr | output | 3 | Latched acknowledge flags of the last completed write |
| seqDone | output | 1 | High once the whole table has been executed |

## Verification
The bench feeds a table that mixes address changes, reset-level steps, a no-op step, a 3 ms pause and a 256 ms pause encoded as zero, and compares every output against a behavioural model on every clock. The engine answers with varying latencies, including completion in the first request cycle. It also sends stray completion pulses with all error flags set while no write is pending. A design that miscounted the pause, treated zero as no pause, or took the address byte from the wrong step would shift or corrupt the request stream. A design that accepted stray completions would show ackErr=7. Restarts during a pause and after completion, plus a reset in mid-run, catch a done flag that sticks, a pending request that survives restart, or a step pointer that is not rewound.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

  localparam int STEP_W = 17;

  localparam logic [7:0] OP_SET_DEV = 8'h00;
  localparam logic [7:0] OP_SET_RST = 8'h01;
  localparam logic [7:0] OP_WAIT_MS = 8'h02;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_PAUSE = 2'd1,
    ST_WRITE = 2'd2,
    ST_IDLE  = 2'd3
  } seqState_e;

  typedef struct packed {
    logic       loadDev;
    logic       loadRst;
    logic       startPause;
    logic       loadWrite;
    logic       latchAck;
    logic [7:0] opReg;
    logic [7:0] opVal;
  } seqStrobe_t;

endpackage

// File: rtl/seq_control.sv
module seq_control
  import init_seq_pkg::*;
#(
  parameter int TABLE_LEN = 4,
  parameter logic [STEP_W-1:0] TABLE [TABLE_LEN] = '{17'h1_0101, 17'h1_0000, 17'h0_0000, 17'h1_0100}
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       pauseDone,
  input  logic       wrDone,
  output seqStrobe_t stb,
  output logic       wrReq,
  output logic       seqDone
);

  localparam int PC_W = (TABLE_LEN > 1) ? $clog2(TABLE_LEN) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(TABLE_LEN - 1);

  seqState_e       state, nextState;
  logic [PC_W-1:0] pc;
  logic [STEP_W-1:0] cur;
  logic            lastStep;
  logic            advance;
  seqStrobe_t      rawStb;

  assign cur      = TABLE[pc];
  assign lastStep = (pc == PC_LAST);

  always_comb begin
    rawStb       = '0;
    rawStb.opReg = cur[15:8];
    rawStb.opVal = cur[7:0];
    advance      = 1'b0;
    nextState    = state;
    case (state)
      ST_FETCH: begin
        if (!cur[16]) begin
          rawStb.loadWrite = 1'b1;
          nextState        = ST_WRITE;
        end else if (cur[15:8] == OP_WAIT_MS) begin
          rawStb.startPause = 1'b1;
          nextState         = ST_PAUSE;
        end else begin
          rawStb.loadDev = (cur[15:8] == OP_SET_DEV);
          rawStb.loadRst = (cur[15:8] == OP_SET_RST);
          advance        = 1'b1;
        end
      end
      ST_PAUSE: advance = pauseDone;
      ST_WRITE: begin
        if (wrDone) begin
          rawStb.latchAck = 1'b1;
          advance         = 1'b1;
        end
      end
      default: ;
    endcase
    if (advance) nextState = lastStep ? ST_IDLE : ST_FETCH;
  end

  assign stb     = restart ? '0 : rawStb;
  assign wrReq   = (state == ST_WRITE);
  assign seqDone = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state <= ST_FETCH;
      pc    <= '0;
    end else begin
      state <= nextState;
      if (advance && !lastStep) pc <= pc + 1'b1;
    end
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import init_seq_pkg::*;
#(
  parameter int CLK_KHZ = 125000
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t stb,
  input  logic [2:0] wrAckErr,
  output logic       pauseDone,
  output logic       rstOut,
  output logic [7:0] wrDev,
  output logic [7:0] wrReg,
  output logic [7:0] wrData,
  output logic [2:0] ackErr
);

  localparam int PRE_W = (CLK_KHZ > 1) ? $clog2(CLK_KHZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_KHZ - 1);
  localparam int MS_W = 9;

  logic [7:0]      devByte;
  logic [PRE_W-1:0] preCnt;
  logic [MS_W-1:0] msLeft;
  logic            msTick;

  assign msTick    = (preCnt == PRE_LAST);
  assign pauseDone = msTick && (msLeft == MS_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      devByte <= '0;
      rstOut  <= 1'b0;
      wrDev   <= '0;
      wrReg   <= '0;
      wrData  <= '0;
      ackErr  <= '0;
    end else begin
      if (stb.loadDev) devByte <= stb.opVal;
      if (stb.loadRst) rstOut  <= stb.opVal[0];
      if (stb.loadWrite) begin
        wrDev  <= devByte;
        wrReg  <= stb.opReg;
        wrData <= stb.opVal;
      end
      if (stb.latchAck) ackErr <= wrAckErr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      msLeft <= '0;
    end else if (stb.startPause) begin
      preCnt <= '0;
      msLeft <= (stb.opVal == 8'd0) ? MS_W'(256) : {1'b0, stb.opVal};
    end else begin
      preCnt <= msTick ? '0 : preCnt + 1'b1;
      if (msTick && msLeft != '0) msLeft <= msLeft - 1'b1;
    end
  end

endmodule

// File: rtl/i2c_init_sequencer.sv
module i2c_init_sequencer
  import init_seq_pkg::*;
#(
  parameter int CLK_KHZ   = 125000,
  parameter int TABLE_LEN = 4,
  parameter logic [STEP_W-1:0] TABLE [TABLE_LEN] = '{17'h1_0101, 17'h1_00A0, 17'h0_1000, 17'h1_0100}
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  output logic       rstOut,
  output logic       wrReq,
  output logic [7:0] wrDev,
  output logic [7:0] wrReg,
  output logic [7:0] wrData,
  input  logic       wrDone,
  input  logic [2:0] wrAckErr,
  output logic [2:0] ackErr,
  output logic       seqDone
);

  seqStrobe_t stb;
  logic       pauseDone;

  seq_control #(.TABLE_LEN(TABLE_LEN), .TABLE(TABLE)) u_ctrl (
    .clk(clk), .rst(rst), .restart(restart), .pauseDone(pauseDone),
    .wrDone(wrDone), .stb(stb), .wrReq(wrReq), .seqDone(seqDone)
  );

  seq_datapath #(.CLK_KHZ(CLK_KHZ)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .wrAckErr(wrAckErr),
    .pauseDone(pauseDone), .rstOut(rstOut), .wrDev(wrDev),
    .wrReg(wrReg), .wrData(wrData), .ackErr(ackErr)
  );

endmodule

// File: rtl/init_seq_checker.sv
module init_seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       restart,
  input logic       wrReq,
  input logic       wrDone,
  input logic [7:0] wrDev,
  input logic [7:0] wrReg,
  input logic [7:0] wrData,
  input logic [2:0] ackErr,
  input logic       seqDone
);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wrReq && !wrDone && !restart) |=> (wrReq && $stable({wrDev, wrReg, wrData})));

  assert_req_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (wrReq && wrDone) |=> !wrReq);

  assert_ack_only_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    !(wrReq && wrDone) |=> $stable(ackErr));

  assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (rst)
    seqDone |-> !wrReq);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (seqDone && !restart) |=> seqDone);

  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!seqDone && !wrReq));

endmodule

bind i2c_init_sequencer init_seq_checker u_chk (.*);

// File: tb/test_i2c_init_sequencer.sv
module test_i2c_init_sequencer;

  localparam int K   = 4;
  localparam int LEN = 11;
  localparam logic [16:0] BT [LEN] = '{
    17'h1_0101,  // rstOut=1
    17'h1_00A4,  // device byte A4
    17'h0_1234,  // write 12<-34
    17'h1_0203,  // pause 3 ms
    17'h1_0100,  // rstOut=0
    17'h1_07FF,  // no-op
    17'h0_5678,  // write 56<-78
    17'h1_0200,  // pause 256 ms
    17'h1_0091,  // device byte 91
    17'h0_9ABC,  // write 9A<-BC
    17'h1_0201   // pause 1 ms
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0;
  logic wrDone = 1'b0;
  logic [2:0] wrAckErr = 3'b000;
  logic rstOut, wrReq, seqDone;
  logic [7:0] wrDev, wrReg, wrData;
  logic [2:0] ackErr;

  always #4 clk = ~clk;

  i2c_init_sequencer #(.CLK_KHZ(K), .TABLE_LEN(LEN), .TABLE(BT)) i_i2c_init_sequencer (
    .clk(clk), .rst(rst), .restart(restart), .rstOut(rstOut), .wrReq(wrReq),
    .wrDev(wrDev), .wrReg(wrReg), .wrData(wrData), .wrDone(wrDone),
    .wrAckErr(wrAckErr), .ackErr(ackErr), .seqDone(seqDone)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: mode 0 fetch, 1 pause, 2 write, 3 done
  int mPc = 0, mMode = 0, mLeft = 0;
  logic [7:0] mDev = 0, mWD = 0, mWR = 0, mWV = 0;
  logic mRst = 0;
  logic [2:0] mAck = 0;
  bit started = 0;

  task automatic mAdvance();
    if (mPc == LEN - 1) mMode = 3;
    else begin mPc++; mMode = 0; end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      mPc = 0; mMode = 0; mDev = 0; mRst = 0; mAck = 0;
    end else if (restart) begin
      mPc = 0; mMode = 0;
    end else begin
      case (mMode)
        0: begin
          logic [16:0] e;
          e = BT[mPc];
          if (!e[16]) begin
            mWD = mDev; mWR = e[15:8]; mWV = e[7:0]; mMode = 2;
          end else if (e[15:8] == 8'h02) begin
            mLeft = ((e[7:0] == 0) ? 256 : int'(e[7:0])) * K;   // R4
            mMode = 1;
          end else begin
            if (e[15:8] == 8'h00) mDev = e[7:0];
            if (e[15:8] == 8'h01) mRst = e[0];
            mAdvance();                                          // R5 R8
          end
        end
        1: if (mLeft == 1) mAdvance(); else mLeft--;
        2: if (wrDone) begin mAck = wrAckErr; mAdvance(); end
        default: ;
      endcase
    end
  end

  // engine responder and per-cycle comparison
  int latList [4] = '{3, 0, 5, 1};
  logic [2:0] ackList [4] = '{3'b000, 3'b010, 3'b101, 3'b100};
  int tIdx = 0, latCnt = -1, cyc = 0;

  always @(negedge clk) begin
    if (started) begin
      chk("R3 rstOut", {31'b0, rstOut}, {31'b0, mRst});
      chk("R4 R5 R6 R8 wrReq", {31'b0, wrReq}, {31'b0, (mMode == 2)});
      if (mMode == 2)
        chk("R2 R6 payload", {8'b0, wrDev, wrReg, wrData}, {8'b0, mWD, mWR, mWV});
      chk("R7 ackErr", {29'b0, ackErr}, {29'b0, mAck});
      chk("R9 R10 seqDone", {31'b0, seqDone}, {31'b0, (mMode == 3)});
    end
    cyc++;
    if (wrDone) begin
      wrDone = 0;
    end else if (wrReq) begin
      if (latCnt < 0) latCnt = latList[tIdx % 4];
      if (latCnt == 0) begin
        wrDone = 1; wrAckErr = ackList[tIdx % 4]; tIdx++; latCnt = -1;
      end else latCnt--;
    end else if (cyc % 29 == 7) begin
      wrDone = 1; wrAckErr = 3'b111;   // stray completion, R7 ignored
    end
  end

  task automatic waitDone();
    int n = 0;
    while (!seqDone && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic pulseRestart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset rstOut", {31'b0, rstOut}, 0);
    chk("R1 reset ackErr", {29'b0, ackErr}, 0);
    chk("R1 reset wrReq", {31'b0, wrReq}, 0);
    chk("R1 reset seqDone", {31'b0, seqDone}, 0);
    rst = 0;
    waitDone();
    chk("R9 first run done", {31'b0, seqDone}, 1);
    repeat (20) @(negedge clk);
    chk("R9 no request after done", {31'b0, wrReq}, 0);
    pulseRestart();
    chk("R10 done cleared", {31'b0, seqDone}, 0);
    repeat (400) @(negedge clk);   // inside the 256 ms pause
    pulseRestart();
    waitDone();
    chk("R9 second run done", {31'b0, seqDone}, 1);
    pulseRestart();
    repeat (6) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R1 mid-run reset ackErr", {29'b0, ackErr}, 0);
    rst = 0;
    waitDone();
    chk("R9 third run done", {31'b0, seqDone}, 1);
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule